// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the word address for a four-beat burst. When a burst starts, it captures a full external address. The low two bits of that address become the burst's starting offset. On each later advance cycle the block steps the offset through the other three words of the same aligned four-word block. The order of the steps depends on a static order-select input. An interleaved order XORs the start offset with the beat number. A linear order adds the beat number to the start offset, modulo four.

The upper address bits are captured at burst start and stay fixed for the whole burst. A cycle with advance deasserted is a wait cycle: the address holds. A flag marks the cycle in which the fourth word of the burst is presented. Advancing past that word wraps back to the start offset inside the same block. The upper bits do not change on a wrap. The design registers its outputs, so every action shows on the outputs one clock after the edge that samples it.

Top module: `bseq_top`

## Requirements
- R1: While reset is asserted (rst_n low), addr_o is all zeros and last_beat_o is 0.
- R2: When burst_start_i is 1 at a clock edge, addr_o equals the addr_i sampled at that edge from the next cycle on, and last_beat_o is 0.
- R3: A burst start takes priority over an advance in the same cycle. With burst_start_i at 1 and adv_n_i at 0, the block loads addr_i and does not step.
- R4: With order_sel_i at 1 (interleaved), the offset addr_o[1:0] follows S, S^1, S^2, S^3 on successive advances, where S is the start offset. For example, start 01 gives 01, 00, 11, 10.
- R5: With order_sel_i at 0 (linear), the offset follows S, S+1, S+2, S+3 modulo 4. For example, start 10 gives 10, 11, 00, 01.
- R6: An advance takes place only when adv_n_i is 0 and burst_start_i is 0. When adv_n_i is 1 and burst_start_i is 0, addr_o and last_beat_o hold their values, whatever addr_i does.
- R7: last_beat_o is 1 exactly while the fourth word of the burst (the third advance after a start) is presented.
- R8: An advance from the fourth word returns the offset to S and clears last_beat_o. addr_o[ADDR_W-1:2] never carries or changes on a wrap.
- R9: Between burst starts, addr_o[ADDR_W-1:2] keeps the value captured at the start, even when addr_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_start_i | input | 1 | Load addr_i and begin a new burst |
| adv_n_i | input | 1 | Advance to the next burst word, active low |
| order_sel_i | input | 1 | Burst order: 1 selects interleaved, 0 selects linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address: captured upper bits and the burst offset |
| last_beat_o | output | 1 | High while the fourth word of the burst is presented |

## Verification
The bench runs bursts from all four start offsets in both orders. Each order has its own sequence for each start, so a design that used one order for both modes, or that always counted from zero, presents the wrong second or third word. Loads arrive together with an advance. A design that lets the advance win shows the start offset plus one instead of the loaded address. Wait cycles are inserted in the middle of a burst while addr_i changes. A design that leaks addr_i or steps during a wait shows the wrong offset or the wrong upper bits. Bursts also run past the fourth word. A wrap that carries into the upper bits changes the high part of the address, and a flag that fails to clear stays high on the fifth word.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] off;
    } lane_t;

endpackage

// File: rtl/bseq_beat.sv
// Beat counter next-state: restarts on load, steps on advance, holds otherwise.
module bseq_beat
    import bseq_pkg::*;
(
    input  logic              load_i,
    input  logic              step_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] beat_o,
    output logic              last_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

    always_comb begin
        if (load_i) begin
            beat_o = '0;
        end else if (step_i) begin
            beat_o = beat_i + 1'b1;
        end else begin
            beat_o = beat_i;
        end
        last_o = (beat_o == LAST_BEAT);
    end
endmodule

// File: rtl/bseq_order.sv
// Maps (start offset, beat number) to a word offset for the selected order.
module bseq_order
    import bseq_pkg::*;
(
    input  order_e            order_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] off_o
);
    logic [BEAT_W-1:0] xor_off;
    logic [BEAT_W-1:0] add_off;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_off[b] = start_i[b] ^ beat_i[b];
    end

    assign add_off = start_i + beat_i;

    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVE: off_o = xor_off;
            default:        off_o = add_off;
        endcase
    end
endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start_i,
    input  logic              adv_n_i,
    input  logic              order_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_beat_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UP_W-1:0] up;
        lane_t           lane;
        logic            last;
    } state_t;

    state_t st_d, st_q;

    logic              load_w;
    logic              step_w;
    logic [BEAT_W-1:0] base_w;
    logic [BEAT_W-1:0] beat_nx;
    logic              last_nx;
    logic [BEAT_W-1:0] off_nx;
    order_e            order_w;

    assign load_w  = burst_start_i;
    assign step_w  = !burst_start_i && !adv_n_i;
    assign base_w  = load_w ? addr_i[BEAT_W-1:0] : st_q.lane.start;
    assign order_w = order_e'(order_sel_i);

    bseq_beat u_beat (
        .load_i (load_w),
        .step_i (step_w),
        .beat_i (st_q.lane.beat),
        .beat_o (beat_nx),
        .last_o (last_nx)
    );

    bseq_order u_order (
        .order_i (order_w),
        .start_i (base_w),
        .beat_i  (beat_nx),
        .off_o   (off_nx)
    );

    always_comb begin
        st_d = st_q;
        if (load_w) begin
            st_d.up         = addr_i[ADDR_W-1:BEAT_W];
            st_d.lane.start = addr_i[BEAT_W-1:0];
        end
        if (load_w || step_w) begin
            st_d.lane.beat = beat_nx;
            st_d.lane.off  = off_nx;
            st_d.last      = last_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o      = {st_q.up, st_q.lane.off};
    assign last_beat_o = st_q.last;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              burst_start_i,
    input logic              adv_n_i,
    input logic              order_sel_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              last_beat_o
);
    logic [1:0] off_w;
    assign off_w = addr_o[1:0];

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_R1: assert (addr_o == '0 && !last_beat_o);
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_i |=> (addr_o == $past(addr_i)) && !last_beat_o);

    // R3: load wins even with advance asserted
    assert_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_start_i && !adv_n_i) |=> addr_o[1:0] == $past(addr_i[1:0]));

    assert_xor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_start_i && !adv_n_i && order_sel_i) |=> (off_w[0] != $past(off_w[0])));

    assert_linear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_start_i && !adv_n_i && !order_sel_i) |=> off_w == 2'($past(off_w) + 2'd1));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_start_i && adv_n_i) |=> $stable(addr_o) && $stable(last_beat_o));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat_o && !burst_start_i && !adv_n_i) |=> !last_beat_o);

    assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_start_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));
endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_bseq_top.sv
`timescale 1ns/1ps
module tb_bseq_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          burst_start_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          order_sel_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic          last_beat_o;

    bseq_top #(.ADDR_W(AW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .burst_start_i (burst_start_i),
        .adv_n_i       (adv_n_i),
        .order_sel_i   (order_sel_i),
        .addr_i        (addr_i),
        .addr_o        (addr_o),
        .last_beat_o   (last_beat_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [AW-1:0] addr;
        logic          last;
        string         req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_s = '0;
    logic [1:0]    m_beat = '0;
    logic [1:0]    m_off = '0;

    function automatic logic [1:0] ord(input logic md, input logic [1:0] s, input logic [1:0] b);
        return md ? (s ^ b) : 2'(s + b);
    endfunction

    task automatic cyc(input logic st, input logic advn, input logic md,
                       input logic [AW-1:0] a, input string req);
        @(negedge clk);
        burst_start_i = st;
        adv_n_i       = advn;
        order_sel_i   = md;
        addr_i        = a;
        if (st) begin
            m_up = a[AW-1:2]; m_s = a[1:0]; m_beat = 2'd0;
            m_off = ord(md, m_s, m_beat);
        end else if (!advn) begin
            m_beat = m_beat + 2'd1;
            m_off = ord(md, m_s, m_beat);
        end
        q.push_back('{addr: {m_up, m_off}, last: (m_beat == 2'd3), req: req});
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (addr_o !== e.addr || last_beat_o !== e.last) begin
                bad++;
                $display("FAIL %s: got addr=%h last=%b exp addr=%h last=%b",
                         e.req, addr_o, last_beat_o, e.addr, e.last);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++; // R1 reset state
        if (addr_o !== '0 || last_beat_o !== 1'b0) begin
            bad++;
            $display("FAIL R1: got addr=%h last=%b exp addr=0 last=0", addr_o, last_beat_o);
        end
        @(negedge clk); rst_n = 1'b1;

        // R4 interleaved, start 01, then wrap R8
        cyc(1, 1, 1, 20'h12345, "R2");
        cyc(0, 0, 1, 20'h00000, "R4");
        cyc(0, 0, 1, 20'h00000, "R4");
        cyc(0, 0, 1, 20'h00000, "R7");
        cyc(0, 0, 1, 20'h00000, "R8");
        cyc(0, 0, 1, 20'h00000, "R8");
        // R5 linear, start 10, with waits R6 and changing addr_i R9
        cyc(1, 1, 0, 20'hABCDE, "R2");
        cyc(0, 0, 0, 20'h11111, "R5");
        cyc(0, 1, 0, 20'hFFFFF, "R6");
        cyc(0, 1, 1, 20'h55555, "R9");
        cyc(0, 0, 0, 20'h22222, "R5");
        cyc(0, 0, 0, 20'h33333, "R7");
        cyc(0, 0, 0, 20'h44444, "R8");
        // R3 load together with advance
        cyc(1, 0, 1, 20'h7F002, "R3");
        cyc(1, 0, 0, 20'h00C03, "R3");
        cyc(0, 0, 0, 20'h00000, "R5");
        // all starts, both orders, full burst and wrap
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1, 1, md[0], {18'(s * 977 + md * 31), 2'(s)}, "R2");
                for (int k = 0; k < 5; k++) begin
                    cyc(0, 0, md[0], 20'hFFFFF, md[0] ? "R4" : "R5");
                    if (k == 1) cyc(0, 1, md[0], 20'h0F0F0, "R6");
                end
            end
        end
        @(negedge clk);
        burst_start_i = 1'b0; adv_n_i = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule